// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer Bank

This block holds five independent down-counters that share a small register port. Each counter is paced by a tick taken from one of two 8-bit prescalers, followed by a per-channel power-of-two divider. Software writes a period and a compare value into buffer registers. It then pulses a per-channel load bit, which copies those buffers into the working counter and comparator. Then it sets the run bit. Four of the channels drive a PWM pin. The fifth is a plain countdown timer whose value software reads back.

A counter steps down once per tick. When it lands on zero it raises a one-cycle interrupt. With reload enabled it takes the buffered period again on the next tick. Without reload it stays at zero. A PWM pin is high while its counter is above the compare value. A compare value of N−d therefore gives d high ticks in a period of N+1 ticks. The pin can be inverted per channel. The register port is a plain synchronous write strobe with a combinational read mux. There is no streaming data path, so no valid/ready handshake is needed or provided.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every register reads 0, every counter is 0, every `pwm_o` bit is low and every `irq_o` bit is low.
- R2: The prescaler field at address 0 bits [7:0] paces channels 0 and 1, and bits [15:8] pace channels 2, 3 and 4. A field value p gives one prescaled pulse every p+1 clocks.
- R3: Divider select lives at address 1, 4 bits per channel, with channel c at bits [4c+3:4c]. A value s of 0 to 4 passes one tick every 2^s prescaled pulses. Values 5 to 15 act as 16.
- R4: The control word at address 2 has a 4-bit group per channel, with channel c at bits [4c+3:4c]. Within a group, bit 0 is run, bit 1 is load, bit 2 is invert and bit 3 is reload. A write takes effect on the following clock.
- R5: While a channel's load bit is set, the working counter and comparator copy the period buffer (address 3+c) and the compare buffer (address 8+c), and counting is held. A buffer write alone leaves the working counter unchanged.
- R6: A running channel decrements once per tick. When it moves from 1 to 0, `irq_o[c]` is high for exactly one clock.
- R7: With reload set, a counter at zero takes the period buffer on its next tick. A period value N then repeats every N+1 ticks.
- R8: With reload clear, a counter that reaches zero stays at zero and raises only one interrupt.
- R9: For channels 0 to 3, `pwm_o[c]` is high, before inversion, while the working counter is greater than the working compare value. With period N and compare N−d, the pin is high for d of every N+1 ticks.
- R10: The invert bit flips `pwm_o[c]` for channels 0 to 3.
- R11: With the run bit clear and load clear, the working counter holds its value.
- R12: Channel 4 has no comparator and no pin. Its working counter reads back at address 20 (addresses 16+c in general), and a period of all ones makes it a free-running countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pwm_o | output | 4 | PWM pins of channels 0 to 3 |
| irq_o | output | 5 | One-cycle zero-reached pulse per channel |

## Verification
A bad prescaler or divider counter shows up as a wrong period. Within one PWM period, the number of high cycles and interrupt pulses on the pins departs from the expected value. A wrong working count or compare value shifts the duty ratio or the interrupt spacing in the very first full period after the channel starts. A counter that moves while stopped, or that changes on a buffer write, differs from the expected value on the next readback of the observe register. Each scenario therefore counts pin activity over whole periods, or compares readback values a few cycles apart.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // Per-channel control group, LSB = run.
  typedef struct packed {
    logic reload;
    logic invert;
    logic load;
    logic run;
  } chan_ctrl_t;

  localparam int GRP_W     = 4;
  localparam int SEL_W     = 4;
  localparam int ADR_PRESC = 0;
  localparam int ADR_DIV   = 1;
  localparam int ADR_CTRL  = 2;
  localparam int ADR_PER0  = 3;
  localparam int ADR_CMP0  = 8;
  localparam int ADR_OBS0  = 16;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int NCH     = 5,
  parameter int PRESC_W = 8,
  parameter int GRP_A_N = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [PRESC_W-1:0]                     presc_a,
  input  logic [PRESC_W-1:0]                     presc_b,
  input  logic [NCH*pwm_timer_pkg::SEL_W-1:0]    divsel,
  output logic [NCH-1:0]                         tick
);
  import pwm_timer_pkg::*;

  localparam int DIV_W = 4;

  logic [1:0]         grp_pulse;
  logic [PRESC_W-1:0] limit [2];
  assign limit[0] = presc_a;
  assign limit[1] = presc_b;

  for (genvar g = 0; g < 2; g++) begin : g_presc
    logic [PRESC_W-1:0] pcnt;
    assign grp_pulse[g] = (pcnt >= limit[g]);
    always_ff @(posedge clk) begin
      if (!rst_n)            pcnt <= '0;
      else if (grp_pulse[g]) pcnt <= '0;
      else                   pcnt <= pcnt + 1'b1;
    end

    // R2: a non-zero, unchanged prescaler never pulses twice in a row
    a_r2_pulse_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_pulse[g] && limit[g] != '0 && $stable(limit[g])) |=> !grp_pulse[g]);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_div
    localparam int G = (c < GRP_A_N) ? 0 : 1;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] dcnt;
    logic [DIV_W-1:0] mask;
    assign sel = divsel[c*SEL_W +: SEL_W];
    always_comb begin
      case (sel)
        4'd0:    mask = 4'h0;
        4'd1:    mask = 4'h1;
        4'd2:    mask = 4'h3;
        4'd3:    mask = 4'h7;
        default: mask = 4'hF;
      endcase
    end
    always_ff @(posedge clk) begin
      if (!rst_n)            dcnt <= '0;
      else if (grp_pulse[G]) dcnt <= dcnt + 1'b1;
    end
    assign tick[c] = grp_pulse[G] && ((dcnt & mask) == mask);
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W   = 16,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  pwm_timer_pkg::chan_ctrl_t ctrl,
  input  logic [CNT_W-1:0]          per_buf,
  input  logic [CNT_W-1:0]          cmp_buf,
  output logic [CNT_W-1:0]          cnt_q,
  output logic                      pwm,
  output logic                      irq
);
  logic [CNT_W-1:0] cmp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (ctrl.load) begin
        cnt_q <= per_buf;
      end else if (ctrl.run && tick) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
          irq   <= (cnt_q == CNT_W'(1));
        end else if (ctrl.reload) begin
          cnt_q <= per_buf;
        end
      end
    end
  end

  if (HAS_CMP) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n)         cmp_q <= '0;
      else if (ctrl.load) cmp_q <= cmp_buf;
    end
    assign pwm = (cnt_q > cmp_q) ^ ctrl.invert;
  end else begin : g_nocmp
    logic unused_cmp_in;
    assign unused_cmp_in = ^{cmp_buf, ctrl.invert};
    assign cmp_q = '0;
    assign pwm   = 1'b0;
  end

  // R6: an interrupt pulse only coincides with a counter sitting at zero
  a_r6_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt_q == '0));
  // R5: load copies the period buffer
  a_r5_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.load |=> (cnt_q == $past(per_buf)));
  // R11: stopped and not loading means frozen
  a_r11_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !ctrl.load) |=> $stable(cnt_q));
  // R8: without reload a zero counter stays at zero
  a_r8_stay_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.load && !ctrl.reload && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int NCH     = 5,
  parameter int NPWM    = 4,
  parameter int CNT_W   = 16,
  parameter int PRESC_W = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  we,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [DATA_W-1:0]                     wdata,
  input  logic [NCH*CNT_W-1:0]                  obs_cnt,
  output logic [PRESC_W-1:0]                    presc_a,
  output logic [PRESC_W-1:0]                    presc_b,
  output logic [NCH*pwm_timer_pkg::SEL_W-1:0]   divsel,
  output logic [NCH*pwm_timer_pkg::GRP_W-1:0]   ctrl,
  output logic [NCH*CNT_W-1:0]                  per_buf,
  output logic [NPWM*CNT_W-1:0]                 cmp_buf,
  output logic [DATA_W-1:0]                     rdata
);
  import pwm_timer_pkg::*;

  localparam int DIV_BITS  = NCH*SEL_W;
  localparam int CTRL_BITS = NCH*GRP_W;

  logic hit_presc, hit_div, hit_ctrl;
  assign hit_presc = we && (addr == ADDR_W'(ADR_PRESC));
  assign hit_div   = we && (addr == ADDR_W'(ADR_DIV));
  assign hit_ctrl  = we && (addr == ADDR_W'(ADR_CTRL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_a <= '0;
      presc_b <= '0;
      divsel  <= '0;
      ctrl    <= '0;
    end else begin
      if (hit_presc) begin
        presc_a <= wdata[PRESC_W-1:0];
        presc_b <= wdata[2*PRESC_W-1:PRESC_W];
      end
      if (hit_div)  divsel <= wdata[DIV_BITS-1:0];
      if (hit_ctrl) ctrl   <= wdata[CTRL_BITS-1:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_per
    always_ff @(posedge clk) begin
      if (!rst_n)
        per_buf[c*CNT_W +: CNT_W] <= '0;
      else if (we && addr == ADDR_W'(ADR_PER0 + c))
        per_buf[c*CNT_W +: CNT_W] <= wdata[CNT_W-1:0];
    end
  end

  for (genvar c = 0; c < NPWM; c++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n)
        cmp_buf[c*CNT_W +: CNT_W] <= '0;
      else if (we && addr == ADDR_W'(ADR_CMP0 + c))
        cmp_buf[c*CNT_W +: CNT_W] <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADR_PRESC)) rdata[2*PRESC_W-1:0] = {presc_b, presc_a};
    if (addr == ADDR_W'(ADR_DIV))   rdata[DIV_BITS-1:0]  = divsel;
    if (addr == ADDR_W'(ADR_CTRL))  rdata[CTRL_BITS-1:0] = ctrl;
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(ADR_PER0 + c)) rdata[CNT_W-1:0] = per_buf[c*CNT_W +: CNT_W];
      if (addr == ADDR_W'(ADR_OBS0 + c)) rdata[CNT_W-1:0] = obs_cnt[c*CNT_W +: CNT_W];
    end
    for (int c = 0; c < NPWM; c++) begin
      if (addr == ADDR_W'(ADR_CMP0 + c)) rdata[CNT_W-1:0] = cmp_buf[c*CNT_W +: CNT_W];
    end
  end

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^wdata;

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank #(
  parameter int NCH     = 5,
  parameter int NPWM    = 4,
  parameter int CNT_W   = 16,
  parameter int PRESC_W = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NPWM-1:0]   pwm_o,
  output logic [NCH-1:0]    irq_o
);
  import pwm_timer_pkg::*;

  logic [PRESC_W-1:0]     presc_a, presc_b;
  logic [NCH*SEL_W-1:0]   divsel;
  logic [NCH*GRP_W-1:0]   ctrl;
  logic [NCH*CNT_W-1:0]   per_buf, obs_cnt;
  logic [NPWM*CNT_W-1:0]  cmp_buf;
  logic [NCH-1:0]         tick, pwm_all;

  pwm_regs #(.NCH(NCH), .NPWM(NPWM), .CNT_W(CNT_W), .PRESC_W(PRESC_W),
             .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .obs_cnt(obs_cnt), .presc_a(presc_a), .presc_b(presc_b), .divsel(divsel),
    .ctrl(ctrl), .per_buf(per_buf), .cmp_buf(cmp_buf), .rdata(reg_rdata)
  );

  pwm_tick_gen #(.NCH(NCH), .PRESC_W(PRESC_W), .GRP_A_N(2)) tick_i (
    .clk(clk), .rst_n(rst_n), .presc_a(presc_a), .presc_b(presc_b),
    .divsel(divsel), .tick(tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam bit WITH_CMP = (c < NPWM);
    logic [CNT_W-1:0] cmp_in;
    if (WITH_CMP) begin : g_c
      assign cmp_in = cmp_buf[c*CNT_W +: CNT_W];
    end else begin : g_n
      assign cmp_in = '0;
    end
    pwm_chan #(.CNT_W(CNT_W), .HAS_CMP(WITH_CMP)) chan_i (
      .clk(clk), .rst_n(rst_n), .tick(tick[c]),
      .ctrl(chan_ctrl_t'(ctrl[c*GRP_W +: GRP_W])),
      .per_buf(per_buf[c*CNT_W +: CNT_W]), .cmp_buf(cmp_in),
      .cnt_q(obs_cnt[c*CNT_W +: CNT_W]), .pwm(pwm_all[c]), .irq(irq_o[c])
    );
  end

  assign pwm_o = pwm_all[NPWM-1:0];

  logic unused_pwm_tail;
  assign unused_pwm_tail = ^pwm_all;

  // R1: straight after reset no pin is driven high
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (pwm_o == '0 && irq_o == '0));

endmodule

// File: tb/pwm_timer_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_timer_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_o;
  logic [4:0]  irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [19:0] ctrl_sh = '0;
  logic [19:0] div_sh  = '0;

  always #2 clk = ~clk;

  pwm_timer_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = 32'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    reg_addr = 5'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic set_grp(int ch, int v);
    ctrl_sh[ch*4 +: 4] = 4'(v);
    wr(2, int'(ctrl_sh));
  endtask

  task automatic set_div(int ch, int v);
    div_sh[ch*4 +: 4] = 4'(v);
    wr(1, int'(div_sh));
  endtask

  // bits: 0 run, 1 load, 2 invert, 3 reload
  task automatic start_ch(int ch, int per, int cmp, int flags);
    wr(3 + ch, per);
    if (ch < 4) wr(8 + ch, cmp);
    set_grp(ch, flags | 2);
    set_grp(ch, flags | 1);
  endtask

  task automatic measure(int ch, int n, output int hi, output int irqs);
    hi = 0; irqs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ch < 4 && pwm_o[ch]) hi++;
      if (irq_o[ch]) irqs++;
    end
  endtask

  task automatic t_reset();
    int v;
    check("R1 pwm", int'(pwm_o), 0);
    check("R1 irq", int'(irq_o), 0);
    rd(2, v);  check("R1 ctrl", v, 0);
    rd(16, v); check("R1 cnt0", v, 0);
  endtask

  task automatic t_duty();
    int hi, ir;
    start_ch(0, 9, 6, 4'b1000);            // R4 group layout, R7 reload
    repeat (20) @(negedge clk);
    measure(0, 50, hi, ir);
    check("R9 duty high", hi, 15);
    check("R6 irq per period", ir, 5);
    check("R7 period N+1", ir * 10, 50);
  endtask

  task automatic t_invert();
    int hi, ir;
    start_ch(1, 9, 6, 4'b1100);
    repeat (20) @(negedge clk);
    measure(1, 50, hi, ir);
    check("R10 inverted high", hi, 35);
  endtask

  task automatic t_oneshot();
    int hi, ir, v;
    start_ch(2, 5, 5, 4'b0000);
    measure(2, 30, hi, ir);
    check("R8 single irq", ir, 1);
    check("R9 low at zero", hi, 0);
    rd(18, v); check("R8 stays zero", v, 0);
  endtask

  task automatic t_presc();
    int hi, ir;
    wr(0, 32'h0000_0100);                  // R2 group B field = 1
    set_div(3, 1);
    start_ch(3, 3, 1, 4'b1000);
    repeat (40) @(negedge clk);
    measure(3, 64, hi, ir);
    check("R2 irq count", ir, 4);
    check("R2 high count", hi, 32);
  endtask

  task automatic t_clamp();
    int hi, ir;
    set_div(0, 9);                         // R3 values above 4 act as 16
    start_ch(0, 1, 1, 4'b1000);
    repeat (64) @(negedge clk);
    measure(0, 64, hi, ir);
    check("R3 clamp irq", ir, 2);
    check("R3 clamp high", hi, 0);
  endtask

  task automatic t_ch4();
    int a, b, hi, ir;
    start_ch(4, 32'hFFFF, 0, 4'b1000);
    measure(4, 100, hi, ir);
    rd(20, a);
    check("R12 counting down", int'(a < 32'hFFFF && a > 32'hFF00), 1);
    check("R12 no early irq", ir, 0);
    set_grp(4, 0);
    rd(20, a);
    repeat (20) @(negedge clk);
    rd(20, b);
    check("R11 frozen", b, a);
    wr(7, 32'h1234);
    rd(20, b);
    check("R5 buffer write no effect", b, a);
    set_grp(4, 2);
    rd(20, b);
    check("R5 load copies", b, 32'h1234);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_duty();
    t_invert();
    t_oneshot();
    t_presc();
    t_clamp();
    t_ch4();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule